// File: doc/BRIEF.md
# Three-Port Bidirectional GPIO with Alternate-Function Override

This block gives software byte-wide access to three general-purpose pin groups. Each group has an output latch and a direction register. Both are reached over a small register bus with single-cycle write and read strobes. When a pin's direction bit is set, the pad is driven from its latch. When the bit is clear, the pad is an input, and its level is brought into the clock domain through a two-flop synchronizer before it can be read.

Resetting the block clears only the direction registers, so every pin comes up as an input. The latches keep their contents through reset. Software is expected to load a latch before it turns the pin into an output, which keeps the pad from glitching.

On the first group, three pins can be claimed by neighbouring peripherals through plain enable inputs:
- **Pin 1** can carry a tone generator output.
- **Pin 2** can become a forced input whose synchronized level is forwarded to a timer capture unit.
- **Pin 3** can carry a timer compare output.

Top module: `gpio_tri_port`

## Requirements
- R1: While reset is asserted and just after it, all three direction registers read 0 and every output-enable (`pa_oe`, `pb_oe`, `pc_oe`) is 0.
- R2: A write to a data address updates the latch whatever the direction bits are. The pad output equals the latch from the cycle after the write, and the output-enable for each bit equals its direction bit.
- R3: For a bit whose direction bit is 0, a data read returns the synchronized pin level. A read strobed in the cycle the pin changes, or in the next cycle, returns the old level. A read strobed two cycles after the change returns the new level.
- R4: For a bit whose direction bit is 1, a data read returns the latch bit. This holds bit by bit when directions are mixed within a port.
- R5: Port A/B/C data sit at addresses 0x00/0x01/0x02 and direction at 0x05/0x06/0x07. Reads of any other address return 0, and writes to them change no register. Read data appears on `bus_rdata` the cycle after the read strobe and holds until the next strobe.
- R6: Port A has 7 bits. Bit 7 of its data and direction registers always reads 0, and writes to that bit are dropped.
- R7: Reset leaves the latches unchanged. After reset, setting a direction bit drives the pre-reset latch value.
- R8: While `dac_en` is 1, `pa_oe[1]` is 1 and `pa_out[1]` follows `dac_tone`, regardless of the port A registers.
- R9: While `cap_en` is 1, `pa_oe[2]` is 0 and `cap_sync` carries the PA2 level two clocks after a change. While `cap_en` is 0, `cap_sync` is 0.
- R10: While `cmp_en` is 1, `pa_oe[3]` is 1 and `pa_out[3]` follows `cmp_level`.
- R11: If a write and a read hit the same address in the same cycle, the read returns the value held before the write, and the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_rdata | output | 8 | Registered read data |
| pa_in | input | 7 | Port A pad input levels |
| pa_out | output | 7 | Port A pad output levels |
| pa_oe | output | 7 | Port A pad output enables |
| pb_in | input | 8 | Port B pad input levels |
| pb_out | output | 8 | Port B pad output levels |
| pb_oe | output | 8 | Port B pad output enables |
| pc_in | input | 8 | Port C pad input levels |
| pc_out | output | 8 | Port C pad output levels |
| pc_oe | output | 8 | Port C pad output enables |
| dac_en | input | 1 | Tone output takes over PA1 |
| dac_tone | input | 1 | Tone level for PA1 |
| cap_en | input | 1 | PA2 forced to input for timer capture |
| cap_sync | output | 1 | Synchronized PA2 level to the capture unit |
| cmp_en | input | 1 | Compare output takes over PA3 |
| cmp_level | input | 1 | Compare level for PA3 |

## Verification
A register write and a read of the same address can land in one cycle. The read must then return the pre-write contents while the write still lands. The bench raises both strobes on the port B direction register in one cycle, checks the old value on the read bus, and then reads again to see the new value. The second collision is between an override and its register settings. The bench changes the port A direction and latch bits while each enable is held and judges the pad outputs against the override rules rather than the register contents.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int GP_AW    = 5;
    localparam int GP_DW    = 8;
    localparam int GP_NPORT = 3;
    localparam int GP_PA_W  = 7;

    // Base addresses; port i sits at base + i
    localparam logic [GP_AW-1:0] GP_DATA_BASE = 5'h00;
    localparam logic [GP_AW-1:0] GP_DIR_BASE  = 5'h05;

    // Port A pins claimed by neighbouring peripherals
    localparam int GP_TONE_BIT = 1;
    localparam int GP_CAP_BIT  = 2;
    localparam int GP_CMP_BIT  = 3;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic [W-1:0] pin_raw,
    output logic [W-1:0] pin_sync
);
    logic [W-1:0] s1_d, s1_q;
    logic [W-1:0] s2_d, s2_q;

    always_comb begin
        s1_d = pin_raw;
        s2_d = s1_q;
    end

    always_ff @(posedge clk) begin
        s1_q <= s1_d;
        s2_q <= s2_d;
    end

    assign pin_sync = s2_q;
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank #(
    parameter int           W    = 8,
    parameter logic [W-1:0] MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_lat,
    input  logic         wr_dir,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pin_sync,
    output logic [W-1:0] lat,
    output logic [W-1:0] dir,
    output logic [W-1:0] rd_val
);
    logic [W-1:0] lat_d, lat_q;
    logic [W-1:0] dir_d, dir_q;

    always_comb begin
        lat_d = lat_q;
        dir_d = dir_q;
        if (wr_lat) lat_d = wdata & MASK;
        if (wr_dir) dir_d = wdata & MASK;
    end

    // Latch survives reset: no reset term on purpose
    always_ff @(posedge clk) begin
        lat_q <= lat_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dir_q <= '0;
        else        dir_q <= dir_d;
    end

    assign lat    = lat_q;
    assign dir    = dir_q;
    assign rd_val = ((dir_q & lat_q) | (~dir_q & pin_sync)) & MASK;
endmodule

// File: rtl/gpio_tri_port.sv
module gpio_tri_port
    import gpio_pkg::*;
#(
    parameter int AW    = GP_AW,
    parameter int DW    = GP_DW,
    parameter int PA_W  = GP_PA_W,
    parameter int NPORT = GP_NPORT
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    input  logic            bus_wr,
    input  logic            bus_rd,
    output logic [DW-1:0]   bus_rdata,
    input  logic [PA_W-1:0] pa_in,
    output logic [PA_W-1:0] pa_out,
    output logic [PA_W-1:0] pa_oe,
    input  logic [DW-1:0]   pb_in,
    output logic [DW-1:0]   pb_out,
    output logic [DW-1:0]   pb_oe,
    input  logic [DW-1:0]   pc_in,
    output logic [DW-1:0]   pc_out,
    output logic [DW-1:0]   pc_oe,
    input  logic            dac_en,
    input  logic            dac_tone,
    input  logic            cap_en,
    output logic            cap_sync,
    input  logic            cmp_en,
    input  logic            cmp_level
);
    localparam logic [DW-1:0] PA_MASK = DW'((1 << PA_W) - 1);

    logic [NPORT-1:0][DW-1:0] pin_raw_all;
    logic [NPORT-1:0][DW-1:0] pin_sync_all;
    logic [NPORT-1:0][DW-1:0] lat_all;
    logic [NPORT-1:0][DW-1:0] dir_all;
    logic [NPORT-1:0][DW-1:0] rdv_all;
    logic [NPORT-1:0]         wr_lat_v;
    logic [NPORT-1:0]         wr_dir_v;

    assign pin_raw_all[0] = DW'(pa_in);
    assign pin_raw_all[1] = pb_in;
    assign pin_raw_all[2] = pc_in;

    // One synchronizer and one register bank per port
    for (genvar gi = 0; gi < NPORT; gi++) begin : g_port
        localparam logic [DW-1:0] MSK = (gi == 0) ? PA_MASK : {DW{1'b1}};

        assign wr_lat_v[gi] = bus_wr && (bus_addr == GP_DATA_BASE + AW'(gi));
        assign wr_dir_v[gi] = bus_wr && (bus_addr == GP_DIR_BASE  + AW'(gi));

        gpio_pin_sync #(.W(DW)) u_sync (
            .clk      (clk),
            .pin_raw  (pin_raw_all[gi]),
            .pin_sync (pin_sync_all[gi])
        );

        gpio_port_bank #(.W(DW), .MASK(MSK)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_lat   (wr_lat_v[gi]),
            .wr_dir   (wr_dir_v[gi]),
            .wdata    (bus_wdata),
            .pin_sync (pin_sync_all[gi]),
            .lat      (lat_all[gi]),
            .dir      (dir_all[gi]),
            .rd_val   (rdv_all[gi])
        );
    end

    // Read path: two-process registered read data
    logic [DW-1:0] rdata_d, rdata_q;
    logic [DW-1:0] rsel;

    always_comb begin
        rsel = '0;
        for (int i = 0; i < NPORT; i++) begin
            if (bus_addr == GP_DATA_BASE + AW'(i)) rsel = rdv_all[i];
            if (bus_addr == GP_DIR_BASE  + AW'(i)) rsel = dir_all[i];
        end
        rdata_d = bus_rd ? rsel : rdata_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign bus_rdata = rdata_q;

    // Port A pad control with peripheral overrides
    always_comb begin
        pa_out = lat_all[0][PA_W-1:0];
        pa_oe  = dir_all[0][PA_W-1:0];
        if (dac_en) begin
            pa_out[GP_TONE_BIT] = dac_tone;
            pa_oe[GP_TONE_BIT]  = 1'b1;
        end
        if (cap_en) begin
            pa_oe[GP_CAP_BIT] = 1'b0;
        end
        if (cmp_en) begin
            pa_out[GP_CMP_BIT] = cmp_level;
            pa_oe[GP_CMP_BIT]  = 1'b1;
        end
    end

    assign cap_sync = cap_en & pin_sync_all[0][GP_CAP_BIT];

    assign pb_out = lat_all[1];
    assign pb_oe  = dir_all[1];
    assign pc_out = lat_all[2];
    assign pc_oe  = dir_all[2];
endmodule

// File: rtl/gpio_tri_port_chk.sv
module gpio_tri_port_chk
    import gpio_pkg::*;
#(
    parameter int AW    = GP_AW,
    parameter int DW    = GP_DW,
    parameter int PA_W  = GP_PA_W,
    parameter int NPORT = GP_NPORT
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [AW-1:0]            bus_addr,
    input logic [DW-1:0]            bus_wdata,
    input logic                     bus_wr,
    input logic                     bus_rd,
    input logic [DW-1:0]            bus_rdata,
    input logic [PA_W-1:0]          pa_out,
    input logic [PA_W-1:0]          pa_oe,
    input logic [DW-1:0]            pb_out,
    input logic                     dac_en,
    input logic                     dac_tone,
    input logic                     cap_en,
    input logic                     cmp_en,
    input logic                     cmp_level,
    input logic [NPORT-1:0][DW-1:0] lat_all,
    input logic [NPORT-1:0][DW-1:0] dir_all
);
    logic unmapped;
    always_comb begin
        unmapped = 1'b1;
        for (int i = 0; i < NPORT; i++) begin
            if (bus_addr == GP_DATA_BASE + AW'(i)) unmapped = 1'b0;
            if (bus_addr == GP_DIR_BASE  + AW'(i)) unmapped = 1'b0;
        end
    end

    // R1
    dir_reset_chk: assert property (@(posedge clk) !rst_n |-> (dir_all == '0));

    // R2
    latch_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == GP_DATA_BASE + AW'(1)) |=> (pb_out == $past(bus_wdata)));

    // R5
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && unmapped) |=> (bus_rdata == '0));

    // R6
    pa_top_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == GP_DATA_BASE || bus_addr == GP_DIR_BASE))
            |=> (lat_all[0][DW-1] == 1'b0 && dir_all[0][DW-1] == 1'b0));

    // R8
    tone_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dac_en |-> (pa_oe[GP_TONE_BIT] && pa_out[GP_TONE_BIT] == dac_tone));

    // R9
    capture_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |-> !pa_oe[GP_CAP_BIT]);

    // R10
    compare_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_en |-> (pa_oe[GP_CMP_BIT] && pa_out[GP_CMP_BIT] == cmp_level));
endmodule

bind gpio_tri_port gpio_tri_port_chk #(
    .AW(AW), .DW(DW), .PA_W(PA_W), .NPORT(NPORT)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .pa_out    (pa_out),
    .pa_oe     (pa_oe),
    .pb_out    (pb_out),
    .dac_en    (dac_en),
    .dac_tone  (dac_tone),
    .cap_en    (cap_en),
    .cmp_en    (cmp_en),
    .cmp_level (cmp_level),
    .lat_all   (lat_all),
    .dir_all   (dir_all)
);

// File: tb/gpio_tri_port_tb_top.sv
module gpio_tri_port_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic [6:0] pa_in = '0;
    logic [6:0] pa_out, pa_oe;
    logic [7:0] pb_in = '0;
    logic [7:0] pb_out, pb_oe;
    logic [7:0] pc_in = '0;
    logic [7:0] pc_out, pc_oe;
    logic       dac_en = 1'b0, dac_tone = 1'b0;
    logic       cap_en = 1'b0, cmp_en = 1'b0, cmp_level = 1'b0;
    logic       cap_sync;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_tri_port dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe),
        .dac_en(dac_en), .dac_tone(dac_tone),
        .cap_en(cap_en), .cap_sync(cap_sync),
        .cmp_en(cmp_en), .cmp_level(cmp_level)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1 oe A", 32'(pa_oe), 0);
        check("R1 oe B", 32'(pb_oe), 0);
        check("R1 oe C", 32'(pc_oe), 0);
        @(negedge clk); rst_n = 1'b1;
        for (int i = 5; i < 8; i++) begin
            rd(5'(i), v);
            check("R1 dir read", 32'(v), 0);
        end
    endtask

    task automatic t_latch_drive();
        logic [7:0] v;
        wr(5'h01, 8'hA5);
        check("R2 oe stays low", 32'(pb_oe), 0);
        check("R2 latch while input", 32'(pb_out), 32'hA5);
        wr(5'h06, 8'hFF);
        check("R2 oe follows dir", 32'(pb_oe), 32'hFF);
        check("R2 pad from latch", 32'(pb_out), 32'hA5);
        pb_in = 8'h00;
        rd(5'h01, v);
        check("R4 output read latch", 32'(v), 32'hA5);
    endtask

    task automatic t_input_lag();
        logic [7:0] v;
        wr(5'h07, 8'h00);
        wr(5'h02, 8'h00);
        pc_in = 8'h00;
        repeat (3) @(negedge clk);
        rd(5'h02, v);
        check("R3 settled low", 32'(v), 0);
        @(negedge clk);
        pc_in = 8'h3C; bus_addr = 5'h02; bus_rd = 1'b1;
        @(negedge clk);
        check("R3 same-cycle read old", 32'(bus_rdata), 0);
        @(negedge clk);
        check("R3 one-cycle read old", 32'(bus_rdata), 0);
        @(negedge clk);
        bus_rd = 1'b0;
        check("R3 two-cycle read new", 32'(bus_rdata), 32'h3C);
        check("R5 rdata holds", 32'(bus_rdata), 32'h3C);
    endtask

    task automatic t_mixed();
        logic [7:0] v;
        wr(5'h02, 8'h99);
        wr(5'h07, 8'h0F);
        pc_in = 8'h66;
        repeat (3) @(negedge clk);
        rd(5'h02, v);
        check("R4 mixed dirs", 32'(v), 32'h69);
        check("R2 oe mixed", 32'(pc_oe), 32'h0F);
    endtask

    task automatic t_map();
        logic [7:0] v;
        wr(5'h04, 8'hFF);
        wr(5'h03, 8'hFF);
        check("R5 no write B oe", 32'(pb_oe), 32'hFF);
        check("R5 no write C oe", 32'(pc_oe), 32'h0F);
        rd(5'h06, v);
        check("R5 dir B addr", 32'(v), 32'hFF);
        rd(5'h03, v); check("R5 unmapped 03", 32'(v), 0);
        rd(5'h04, v); check("R5 unmapped 04", 32'(v), 0);
        rd(5'h08, v); check("R5 unmapped 08", 32'(v), 0);
        rd(5'h1F, v); check("R5 unmapped 1F", 32'(v), 0);
    endtask

    task automatic t_pa_top();
        logic [7:0] v;
        wr(5'h00, 8'hFF);
        wr(5'h05, 8'hFF);
        rd(5'h00, v); check("R6 data bit7", 32'(v), 32'h7F);
        rd(5'h05, v); check("R6 dir bit7", 32'(v), 32'h7F);
        check("R6 pa oe", 32'(pa_oe), 32'h7F);
    endtask

    task automatic t_reset_keeps();
        logic [7:0] v;
        wr(5'h01, 8'h5A);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R7 oe cleared", 32'(pb_oe), 0);
        rst_n = 1'b1;
        wr(5'h06, 8'hFF);
        check("R7 latch kept", 32'(pb_out), 32'h5A);
        rd(5'h01, v);
        check("R7 latch read", 32'(v), 32'h5A);
    endtask

    task automatic t_dac();
        wr(5'h00, 8'h00);
        wr(5'h05, 8'h00);
        @(negedge clk); dac_en = 1'b1; dac_tone = 1'b1; #1;
        check("R8 tone oe", 32'(pa_oe[1]), 1);
        check("R8 tone high", 32'(pa_out[1]), 1);
        dac_tone = 1'b0; #1;
        check("R8 tone low", 32'(pa_out[1]), 0);
        wr(5'h00, 8'h02);
        check("R8 latch ignored", 32'(pa_out[1]), 0);
        @(negedge clk); dac_en = 1'b0; #1;
        check("R8 release", 32'(pa_oe[1]), 0);
    endtask

    task automatic t_cap();
        wr(5'h05, 8'h7F);
        @(negedge clk); cap_en = 1'b1; pa_in[2] = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R9 forced input", 32'(pa_oe[2]), 0);
        check("R9 other pins out", 32'(pa_oe), 32'h7B);
        check("R9 low before", 32'(cap_sync), 0);
        pa_in[2] = 1'b1;
        @(negedge clk);
        check("R9 one clock lag", 32'(cap_sync), 0);
        @(negedge clk);
        check("R9 two clock", 32'(cap_sync), 1);
        cap_en = 1'b0; #1;
        check("R9 gated off", 32'(cap_sync), 0);
        check("R9 released", 32'(pa_oe[2]), 1);
        wr(5'h05, 8'h00);
    endtask

    task automatic t_cmp();
        wr(5'h00, 8'h00);
        @(negedge clk); cmp_en = 1'b1; cmp_level = 1'b1; #1;
        check("R10 oe", 32'(pa_oe[3]), 1);
        check("R10 level", 32'(pa_out[3]), 1);
        cmp_level = 1'b0; #1;
        check("R10 level low", 32'(pa_out[3]), 0);
        @(negedge clk); cmp_en = 1'b0; #1;
        check("R10 release", 32'(pa_oe[3]), 0);
    endtask

    task automatic t_collide();
        logic [7:0] v;
        wr(5'h06, 8'hFF);
        @(negedge clk);
        bus_addr = 5'h06; bus_wdata = 8'h11; bus_wr = 1'b1; bus_rd = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        check("R11 read old", 32'(bus_rdata), 32'hFF);
        check("R11 write lands", 32'(pb_oe), 32'h11);
        rd(5'h06, v);
        check("R11 read new", 32'(v), 32'h11);
    endtask

    initial begin
        repeat (CLK_PERIOD * 10000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_latch_drive();
        t_input_lag();
        t_mixed();
        t_map();
        t_pa_top();
        t_reset_keeps();
        t_dac();
        t_cap();
        t_cmp();
        t_collide();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule